// File: doc/BRIEF.md
# Phase-Frequency Detector with Programmable Antibacklash

This block compares a divided reference clock with a divided feedback clock and produces the two pump requests (pump_up, pump_dn) that steer an external charge pump. Everything runs on one fast sampling clock. Rising edges on both inputs are detected. The reference first passes through a programmable 1..16383 divider. A reference tick sets the up request and a feedback tick sets the down request. Once both requests are active, they stay active together for a programmable interval of 1 to 4 fast-clock cycles and then clear together. That interval is the antibacklash overlap.

A chip-enable pin and a software power-down bit together gate the block. When it is gated off, both pump requests are low, a three-state indication is raised, and the divider, detector and lock logic all return to their idle state. Two 3-bit pump-current settings are carried through to a current-select output, and a select input chooses between them. A digital lock monitor counts consecutive comparisons in which the two requests started within a small skew window. A status multiplexer can drive the lock flag or one of the internal tick streams on a single status pin.

Top module: `pfd_antibacklash`

## Requirements
- R1: With divide value R on ref_ratio, a divided reference tick occurs on every R-th rising edge of ref_in, counted from the last time the block was idle. A value of 0 behaves as 1.
- R2: A divided reference tick sets pump_up and a feedback tick sets pump_dn. A rising edge sampled at clock edge k shows on the request from edge k+1 on.
- R3: While pump_up and pump_dn are both high, they stay high together for abp_sel+1 cycles (codes 00, 01, 10, 11 give 1, 2, 3, 4 cycles) and then both clear on the same edge.
- R4: When the reference leads the feedback by d cycles, pump_up is high for d+abp_sel+1 cycles and pump_dn for abp_sel+1 cycles. A lag gives the mirror result, and equal phase gives abp_sel+1 on both.
- R5: When chip_en is 0, pump_up and pump_dn are 0 and pump_hiz is 1. The divider count, detector flops and lock state are cleared.
- R6: When chip_en is 1 and pd_bit is 1, the block behaves as in R5. Normal operation resumes only with chip_en 1 and pd_bit 0.
- R7: cur_sel_out equals cur_set_a when cur_pick is 0 and cur_set_b when cur_pick is 1, in the same cycle.
- R8: lock_det rises after LOCK_N (default 4) consecutive comparisons whose skew is at most WIN (default 2) cycles. The skew is the number of cycles in which exactly one request was high.
- R9: lock_det falls, and the good-comparison count restarts, on the first cycle in which the skew of the current comparison exceeds WIN.
- R10: stat_sel chooses what drives stat_out: 00 gives lock_det, 01 gives the divided reference tick, 10 gives the feedback tick, and 11 gives constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference input before division |
| fb_in | input | 1 | Divided feedback input |
| ref_ratio | input | 14 | Reference divide value (0 acts as 1) |
| abp_sel | input | 2 | Antibacklash overlap code |
| chip_en | input | 1 | Chip enable, low gates the block off |
| pd_bit | input | 1 | Software power-down bit |
| cur_set_a | input | 3 | First pump-current setting |
| cur_set_b | input | 3 | Second pump-current setting |
| cur_pick | input | 1 | Chooses the current setting |
| stat_sel | input | 2 | Status multiplexer select |
| pump_up | output | 1 | Up pump request |
| pump_dn | output | 1 | Down pump request |
| pump_hiz | output | 1 | Pump three-state indication |
| cur_sel_out | output | 3 | Selected current setting |
| lock_det | output | 1 | Digital lock flag |
| stat_out | output | 1 | Multiplexed status output |

## Verification
The bench sweeps every antibacklash code against leads and lags of up to three cycles and checks both request widths. A design that counted the overlap off by one, or cleared only one flop, shows a wrong width here. Lock is checked at exactly the LOCK_N-th good comparison, on comparisons at the skew window edge that must still count, and on a too-wide skew that must drop lock. An off-by-one in the window comparison, or a drop that came late, fails these checks. The divider is exercised with R=3 and with R=0, so a count that wraps one edge too early or too late, or that treats 0 as a huge divider, changes the number of ticks seen. Both gating paths are checked for the idle, three-state outputs, and every current-setting pair is checked under both selects.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    STAT_LOCK  = 2'b00,
    STAT_REFTK = 2'b01,
    STAT_FBTK  = 2'b10,
    STAT_ZERO  = 2'b11
  } stat_sel_e;
endpackage

// File: rtl/edge_pulse.sv
module edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sig,
  output logic tick
);
  logic sig_q, sig_q_n;
  logic tick_q, tick_n;

  always_comb begin
    sig_q_n = sig;
    tick_n  = en & sig & ~sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      sig_q  <= sig_q_n;
      tick_q <= tick_n;
    end
  end

  assign tick = tick_q;

  // a rising edge needs a low sample in between, so ticks never repeat back to back
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int RW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rise_tick,
  input  logic [RW-1:0] ratio,
  output logic          div_tick
);
  logic [RW-1:0] cnt_q, cnt_n;
  logic [RW-1:0] limit;
  logic          hit;

  always_comb begin
    limit = (ratio == '0) ? '0 : ratio - 1'b1;
    hit   = (cnt_q >= limit);
    cnt_n = cnt_q;
    if (!en)            cnt_n = '0;
    else if (rise_tick) cnt_n = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign div_tick = en & rise_tick & hit;

  assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] abp,
  input  logic       ref_tick,
  input  logic       fb_tick,
  output logic       up,
  output logic       dn,
  output logic       cmp_done
);
  logic       up_q, up_n, dn_q, dn_n;
  logic [1:0] rcnt_q, rcnt_n;
  logic       both, done;

  always_comb begin
    both   = up_q & dn_q;
    done   = both & (rcnt_q >= abp);
    up_n   = up_q | ref_tick;
    dn_n   = dn_q | fb_tick;
    rcnt_n = rcnt_q;
    if (!en) begin
      up_n   = 1'b0;
      dn_n   = 1'b0;
      rcnt_n = '0;
    end else if (done) begin
      up_n   = ref_tick;
      dn_n   = fb_tick;
      rcnt_n = '0;
    end else if (both) begin
      rcnt_n = rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      rcnt_q <= '0;
    end else begin
      up_q   <= up_n;
      dn_q   <= dn_n;
      rcnt_q <= rcnt_n;
    end
  end

  assign up       = up_q;
  assign dn       = dn_q;
  assign cmp_done = en & done;

  assert_ref_sets_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_tick) |=> up_q);
  assert_fb_sets_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fb_tick) |=> dn_q);
  assert_overlap_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up_q && dn_q && rcnt_q >= abp && !ref_tick && !fb_tick) |=> (!up_q && !dn_q));
endmodule

// File: rtl/lock_mon.sv
module lock_mon #(
  parameter int LOCK_N = 4,
  parameter int WIN    = 2,
  parameter int SKW    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic up,
  input  logic dn,
  input  logic cmp_done,
  output logic lock
);
  localparam int LKW = $clog2(LOCK_N + 1);
  localparam logic [SKW-1:0] WIN_V  = SKW'(WIN);
  localparam logic [SKW-1:0] SKW_MX = '1;
  localparam logic [LKW-1:0] LK_TOP = LKW'(LOCK_N);

  logic [SKW-1:0] skew_q, skew_n;
  logic [LKW-1:0] lk_q, lk_n;
  logic           one_side, fail, good;

  always_comb begin
    one_side = up ^ dn;
    fail     = one_side & (skew_q >= WIN_V);
    good     = cmp_done & (skew_q <= WIN_V);
    skew_n   = skew_q;
    if (!en || cmp_done)                skew_n = '0;
    else if (one_side && skew_q != SKW_MX) skew_n = skew_q + 1'b1;
    lk_n = lk_q;
    if (!en || fail)                    lk_n = '0;
    else if (good && lk_q != LK_TOP)    lk_n = lk_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skew_q <= '0;
      lk_q   <= '0;
    end else begin
      skew_q <= skew_n;
      lk_q   <= lk_n;
    end
  end

  assign lock = (lk_q == LK_TOP);

  assert_skew_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (up ^ dn) && skew_q >= WIN_V) |=> !lock);
  assert_lock_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(cmp_done));
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash #(
  parameter int RW     = 14,
  parameter int CW     = 3,
  parameter int LOCK_N = 4,
  parameter int WIN    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic [RW-1:0] ref_ratio,
  input  logic [1:0]    abp_sel,
  input  logic          chip_en,
  input  logic          pd_bit,
  input  logic [CW-1:0] cur_set_a,
  input  logic [CW-1:0] cur_set_b,
  input  logic          cur_pick,
  input  logic [1:0]    stat_sel,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          pump_hiz,
  output logic [CW-1:0] cur_sel_out,
  output logic          lock_det,
  output logic          stat_out
);
  import pfd_pkg::*;

  logic [1:0] rs_q, rs_n;
  logic       rst_i_n;
  logic       active;
  logic       ref_rise, ref_tick, fb_tick;
  logic       up, dn, cmp_done, lock;
  stat_sel_e  ssel;

  always_comb rs_n = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= rs_n;
  end

  assign rst_i_n = rs_q[1];
  assign active  = chip_en & ~pd_bit;

  edge_pulse u_ref_edge (
    .clk(clk), .rst_n(rst_i_n), .en(active), .sig(ref_in), .tick(ref_rise)
  );

  edge_pulse u_fb_edge (
    .clk(clk), .rst_n(rst_i_n), .en(active), .sig(fb_in), .tick(fb_tick)
  );

  ref_divider #(.RW(RW)) u_rdiv (
    .clk(clk), .rst_n(rst_i_n), .en(active), .rise_tick(ref_rise),
    .ratio(ref_ratio), .div_tick(ref_tick)
  );

  pfd_core u_core (
    .clk(clk), .rst_n(rst_i_n), .en(active), .abp(abp_sel),
    .ref_tick(ref_tick), .fb_tick(fb_tick),
    .up(up), .dn(dn), .cmp_done(cmp_done)
  );

  lock_mon #(.LOCK_N(LOCK_N), .WIN(WIN)) u_lock (
    .clk(clk), .rst_n(rst_i_n), .en(active), .up(up), .dn(dn),
    .cmp_done(cmp_done), .lock(lock)
  );

  always_comb begin
    ssel        = stat_sel_e'(stat_sel);
    pump_up     = up & active;
    pump_dn     = dn & active;
    pump_hiz    = ~active;
    cur_sel_out = cur_pick ? cur_set_b : cur_set_a;
    lock_det    = lock;
    case (ssel)
      STAT_LOCK:  stat_out = lock;
      STAT_REFTK: stat_out = ref_tick;
      STAT_FBTK:  stat_out = fb_tick;
      default:    stat_out = 1'b0;
    endcase
  end

  assert_idle_pump_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !chip_en |-> (!pump_up && !pump_dn && pump_hiz));
  assert_swpd_idle_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (chip_en && pd_bit) |=> !lock_det);
endmodule

// File: tb/tb_pfd_antibacklash.sv
module tb_pfd_antibacklash;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_in, fb_in;
  logic [13:0] ref_ratio;
  logic [1:0]  abp_sel;
  logic        chip_en, pd_bit;
  logic [2:0]  cur_set_a, cur_set_b;
  logic        cur_pick;
  logic [1:0]  stat_sel;
  logic        pump_up, pump_dn, pump_hiz, lock_det, stat_out;
  logic [2:0]  cur_sel_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  pfd_antibacklash dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .ref_ratio(ref_ratio), .abp_sel(abp_sel), .chip_en(chip_en), .pd_bit(pd_bit),
    .cur_set_a(cur_set_a), .cur_set_b(cur_set_b), .cur_pick(cur_pick),
    .stat_sel(stat_sel), .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .cur_sel_out(cur_sel_out), .lock_det(lock_det), .stat_out(stat_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one comparison: reference leads by d (negative d = lag), widths counted
  task automatic run_cmp(input int d, input int abp, output int uw, output int dw);
    int ra, fa;
    ra = (d < 0) ? -d : 0;
    fa = (d > 0) ? d : 0;
    uw = 0; dw = 0;
    abp_sel = abp[1:0];
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pump_up) uw++;
      if (pump_dn) dw++;
      ref_in = (i >= ra && i < ra + 12);
      fb_in  = (i >= fa && i < fa + 12);
    end
  endtask

  task automatic idle_pulse();
    @(negedge clk); chip_en = 1'b0;
    @(negedge clk); chip_en = 1'b1;
    @(negedge clk);
  endtask

  // n pulses on ref (which=0) or fb (which=1), counting stat_out high samples
  task automatic pulse_cnt(input int which, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < 4 * n + 3; i++) begin
      @(negedge clk);
      if (stat_out) cnt++;
      if (which == 0) ref_in = (i < 4 * n) && (i % 4 < 2);
      else            fb_in  = (i < 4 * n) && (i % 4 < 2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int uw, dw, c, eu, ed, ad;
    rst_n = 1'b0; ref_in = 0; fb_in = 0; ref_ratio = 14'd1; abp_sel = 2'b00;
    chip_en = 1'b1; pd_bit = 1'b0; cur_set_a = 0; cur_set_b = 0; cur_pick = 0;
    stat_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 reset pump_up", pump_up, 0);
    chk("R5 reset pump_dn", pump_dn, 0);
    chk("R8 reset lock_det", lock_det, 0);
    chk("R5 reset pump_hiz", pump_hiz, 0);

    // R3 R4: sweep overlap codes against leads and lags
    for (int a = 0; a < 4; a++) begin
      for (int d = -3; d <= 3; d++) begin
        run_cmp(d, a, uw, dw);
        ad = (d < 0) ? -d : d;
        eu = a + 1 + ((d > 0) ? ad : 0);
        ed = a + 1 + ((d < 0) ? ad : 0);
        chk($sformatf("R4 up width abp=%0d d=%0d", a, d), uw, eu);
        chk($sformatf("R3 dn width abp=%0d d=%0d", a, d), dw, ed);
      end
    end

    // R8 R9: lock
    idle_pulse();
    for (int k = 0; k < 3; k++) run_cmp(0, 0, uw, dw);
    chk("R8 lock low after 3", lock_det, 0);
    run_cmp(0, 0, uw, dw);
    chk("R8 lock high after 4", lock_det, 1);
    run_cmp(2, 1, uw, dw);
    chk("R8 lock kept skew=WIN lead", lock_det, 1);
    run_cmp(-2, 0, uw, dw);
    chk("R8 lock kept skew=WIN lag", lock_det, 1);
    stat_sel = 2'b00;
    @(negedge clk);
    chk("R10 stat lock route", stat_out, 1);
    run_cmp(3, 0, uw, dw);
    chk("R9 lock dropped skew=WIN+1", lock_det, 0);
    run_cmp(0, 0, uw, dw);
    chk("R9 count restarted", lock_det, 0);

    // R5: chip enable low
    chip_en = 1'b0;
    run_cmp(0, 2, uw, dw);
    chk("R5 up idle", uw, 0);
    chk("R5 dn idle", dw, 0);
    chk("R5 hiz", pump_hiz, 1);
    chk("R5 lock cleared", lock_det, 0);

    // R6: software power-down
    chip_en = 1'b1; pd_bit = 1'b1;
    run_cmp(1, 2, uw, dw);
    chk("R6 up idle", uw, 0);
    chk("R6 dn idle", dw, 0);
    chk("R6 hiz", pump_hiz, 1);
    pd_bit = 1'b0;
    run_cmp(1, 2, uw, dw);
    chk("R6 resume up", uw, 4);
    chk("R6 resume dn", dw, 3);
    chk("R6 hiz off", pump_hiz, 0);

    // R1 R10: divider and status routing
    stat_sel = 2'b01; ref_ratio = 14'd3;
    idle_pulse();
    pulse_cnt(0, 9, c);
    chk("R1 ratio 3 ticks", c, 3);
    ref_ratio = 14'd0;
    idle_pulse();
    pulse_cnt(0, 5, c);
    chk("R1 ratio 0 ticks", c, 5);
    stat_sel = 2'b10;
    pulse_cnt(1, 4, c);
    chk("R10 fb tick route", c, 4);
    stat_sel = 2'b11;
    pulse_cnt(0, 3, c);
    chk("R10 zero route", c, 0);
    ref_ratio = 14'd1;
    idle_pulse();

    // R7: current selection, all pairs
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 8; x++)
        for (int y = 0; y < 8; y++) begin
          @(negedge clk);
          cur_pick = s[0]; cur_set_a = x[2:0]; cur_set_b = y[2:0];
          #1;
          chk("R7 cur select", cur_sel_out, (s == 1) ? y : x);
        end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule